// File: doc/BRIEF.md
# Eight-Channel DAC Serial Command Decoder

This block is the digital register model behind an eight-channel digital-to-analog converter that is driven by a 32-bit serial word. A host lowers an active-low frame select (`sync_n`), presents the most significant bit first on `sdin`, and the block samples each bit on a falling edge of `sclk`. All three serial inputs are brought into the system clock domain through synchronizer stages. When the 32nd bit arrives, the word is decoded into a command, a channel address, a data value and a feature field.

Each channel has two registers. An input (staging) register can be loaded without disturbing the output. An active register drives the converter code. Channels can be committed one at a time or all together. A masked power-down command gives any subset of channels one of three termination modes, or powers them back up. A reference command switches the internal reference on or off, and the block reports when an external reference is needed.

The active codes, the per-channel power state and the reference state are presented as registered outputs that feed the analog stage.

Top module: `octdac_cmd_top`

## Requirements
- R1: A frame is 32 bits sent most significant bit first. Each bit is sampled on a falling `sclk` edge while `sync_n` is low. Bit 31 is a guard bit. Bits 30:28 are ignored. Bits 27:24 hold the command, bits 23:20 the channel address and bits 19:4 the data value (left aligned). Bits 3:0 are not used by the commands implemented here.
- R2: No state changes before the 32nd falling edge of a frame. The decoded update appears on the outputs a few system clocks after that edge, while `sync_n` is still low.
- R3: A frame is discarded with no state change if `sync_n` rises before its 32nd edge. Further `sclk` edges after the 32nd are ignored until `sync_n` goes high again.
- R4: A completed frame whose bit 31 is 1 is discarded with no state change.
- R5: Address values 0 to 7 select channels A to H, and channel i drives `dac_code[i*16 +: 16]`. Address 4'b1111 selects all eight channels. Addresses 8 to 14 select no channel.
- R6: Command 4'b0000 stores the data in the input registers of the selected channels. Every active register and `dac_code` stays unchanged.
- R7: Command 4'b0010 stores the data in the selected input registers. In the same update it copies every channel's input register, including the new value, into its active register.
- R8: Command 4'b0011 stores the data in the selected input registers and commits only the selected channels to their active registers. The other channels keep their active values.
- R9: Command 4'b0100 is power-down and ignores the address field. Bits 7:0 form a channel mask, with bit 0 for A through bit 7 for H. Bits 9:8 give the mode: 00 powered up, 01 1 kΩ to ground, 10 100 kΩ to ground, 11 high impedance. Channel i's mode appears on `pd_mode[2*i +: 2]`. Only channels whose mask bit is set change mode.
- R10: Command 4'b1001 sets the reference from bits 19:17. Code 101 turns it on and clears `ext_ref`. Code 110 turns it off and sets `ext_ref`. Any other code changes nothing.
- R11: All other command values leave every output unchanged.
- R12: After reset all input and active registers are zero, every channel is powered up, `ref_on` is 1 and `ext_ref` is 0.
- R13: A channel in any power-down mode still accepts input-register and active-register updates, and its `dac_code` changes accordingly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock; bits are taken on its falling edges |
| sync_n | input | 1 | Active-low frame select |
| sdin | input | 1 | Serial data, most significant bit first |
| dac_code | output | 128 | Active codes, channel i in bits [i*16 +: 16] |
| pd_mode | output | 16 | Power mode per channel, channel i in bits [2*i +: 2] |
| ref_on | output | 1 | Internal reference enabled |
| ext_ref | output | 1 | An external reference is required |

## Verification
Directed frames cover four patterns. Staging-only writes followed by one broadcast commit show whether staged values are held back and then released together. Single-channel commits to consecutive channels expose any crosstalk between channels. Power-down frames with mixed masks, modes and a nonzero address field separate mask handling from address decoding. Guard-bit, truncated, over-long and unknown-command frames show whether anything leaks through on a frame that must be discarded. A check taken between the 31st and 32nd edges separates a commit on the 32nd edge from an early one. Seeded random frames then mix all commands and addresses against a bench model, which catches ordering errors such as committing a stale staged value instead of the newly written one.

// File: rtl/octdac_pkg.sv
package octdac_pkg;
  localparam int FRAME_W = 32;

  localparam int GUARD_BIT = 31;
  localparam int CMD_HI    = 27;
  localparam int ADDR_HI   = 23;
  localparam int DATA_HI   = 19;
  localparam int REF_HI    = 19;
  localparam int MODE_LO   = 8;

  typedef enum logic [3:0] {
    OP_STAGE      = 4'b0000,
    OP_STAGE_ALL  = 4'b0010,
    OP_STAGE_ONE  = 4'b0011,
    OP_POWER      = 4'b0100,
    OP_REFERENCE  = 4'b1001
  } op_e;

  typedef enum logic [1:0] {
    PWR_ACTIVE = 2'b00,
    PWR_R1K    = 2'b01,
    PWR_R100K  = 2'b10,
    PWR_OPEN   = 2'b11
  } pwr_e;

  localparam logic [3:0] ADDR_BROADCAST = 4'hF;
  localparam logic [2:0] REFSEL_ON  = 3'b101;
  localparam logic [2:0] REFSEL_OFF = 3'b110;
endpackage

// File: rtl/octdac_serial_rx.sv
module octdac_serial_rx
  import octdac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk,
  input  logic               sync_n,
  input  logic               sdin,
  output logic               word_vld,
  output logic [FRAME_W-1:0] word
);
  localparam int CW = $clog2(FRAME_W + 1);
  localparam logic [CW-1:0] LAST = CW'(FRAME_W - 1);
  localparam logic [CW-1:0] FULL = CW'(FRAME_W);

  logic [SYNC_STAGES:0]   ck_s;
  logic [SYNC_STAGES-1:0] fs_s;
  logic [SYNC_STAGES-1:0] dt_s;
  logic [CW-1:0]          bit_cnt;
  logic [FRAME_W-2:0]     shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_s <= '1;
      fs_s <= '1;
      dt_s <= '0;
    end else begin
      ck_s <= {ck_s[SYNC_STAGES-1:0], sclk};
      fs_s <= {fs_s[SYNC_STAGES-2:0], sync_n};
      dt_s <= {dt_s[SYNC_STAGES-2:0], sdin};
    end
  end

  logic fall, framing, din;
  assign fall    = ck_s[SYNC_STAGES] & ~ck_s[SYNC_STAGES-1];
  assign framing = ~fs_s[SYNC_STAGES-1];
  assign din     = dt_s[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    word_vld <= 1'b0;
    if (rst) begin
      bit_cnt <= '0;
      shreg   <= '0;
      word    <= '0;
    end else if (!framing) begin
      bit_cnt <= '0;
    end else if (fall && bit_cnt < FULL) begin
      shreg   <= {shreg[FRAME_W-3:0], din};
      bit_cnt <= bit_cnt + 1'b1;
      if (bit_cnt == LAST) begin
        word_vld <= 1'b1;
        word     <= {shreg, din};
      end
    end
  end

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= FULL) else $error("bit counter past frame length");

  assert_commit_edge_R2: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> $past(bit_cnt) == LAST) else $error("word out before last bit");

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    word_vld |=> !word_vld) else $error("word strobe longer than one cycle");
endmodule

// File: rtl/octdac_decode.sv
module octdac_decode
  import octdac_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               word_vld,
  input  logic [FRAME_W-1:0] word,
  output logic [NCH-1:0]     stage_we,
  output logic [NCH-1:0]     commit,
  output logic [DW-1:0]      value,
  output logic               pwr_we,
  output logic [NCH-1:0]     pwr_mask,
  output logic [1:0]         pwr_sel,
  output logic               ref_we,
  output logic               ref_val
);
  logic       ok;
  logic [3:0] op;
  logic [3:0] addr;
  logic [2:0] refsel;
  logic [NCH-1:0] hit;

  assign ok       = word_vld & ~word[GUARD_BIT];
  assign op       = word[CMD_HI -: 4];
  assign addr     = word[ADDR_HI -: 4];
  assign refsel   = word[REF_HI -: 3];
  assign value    = word[DATA_HI -: DW];
  assign pwr_mask = word[NCH-1:0];
  assign pwr_sel  = word[MODE_LO +: 2];
  assign ref_val  = (refsel == REFSEL_ON);

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      hit[i] = (addr == ADDR_BROADCAST) || (addr == 4'(i));
    end
  end

  always_comb begin
    stage_we = '0;
    commit   = '0;
    pwr_we   = 1'b0;
    ref_we   = 1'b0;
    if (ok) begin
      case (op)
        OP_STAGE:     stage_we = hit;
        OP_STAGE_ALL: begin stage_we = hit; commit = '1; end
        OP_STAGE_ONE: begin stage_we = hit; commit = hit; end
        OP_POWER:     pwr_we = 1'b1;
        OP_REFERENCE: ref_we = (refsel == REFSEL_ON) || (refsel == REFSEL_OFF);
        default: ;
      endcase
    end
  end

  assert_guard_drop_R4: assert property (@(posedge clk) disable iff (rst)
    (word_vld && word[GUARD_BIT]) |-> (stage_we == '0 && commit == '0 && !pwr_we && !ref_we))
    else $error("guard-bit frame produced an action");

  assert_one_action_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({|stage_we, pwr_we, ref_we})) else $error("more than one action class");

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !word_vld |-> (commit == '0 && stage_we == '0 && !pwr_we && !ref_we))
    else $error("action without a completed frame");
endmodule

// File: rtl/octdac_chan_regs.sv
module octdac_chan_regs
  import octdac_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NCH-1:0]          stage_we,
  input  logic [NCH-1:0]          commit,
  input  logic [DW-1:0]           value,
  input  logic                    pwr_we,
  input  logic [NCH-1:0]          pwr_mask,
  input  logic [1:0]              pwr_sel,
  input  logic                    ref_we,
  input  logic                    ref_val,
  output logic [NCH-1:0][DW-1:0]  act_q,
  output logic [NCH-1:0][1:0]     pwr_q,
  output logic                    ref_q,
  output logic                    ext_q
);
  logic [NCH-1:0][DW-1:0] stage_q;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) stage_q[g] <= '0;
      else if (stage_we[g]) stage_q[g] <= value;
    end

    always_ff @(posedge clk) begin
      if (rst) act_q[g] <= '0;
      else if (commit[g]) act_q[g] <= stage_we[g] ? value : stage_q[g];
    end

    always_ff @(posedge clk) begin
      if (rst) pwr_q[g] <= PWR_ACTIVE;
      else if (pwr_we && pwr_mask[g]) pwr_q[g] <= pwr_sel;
    end

    assert_hold_act_R6: assert property (@(posedge clk) disable iff (rst)
      !commit[g] |=> $stable(act_q[g])) else $error("active code moved without commit");

    assert_commit_copy_R7: assert property (@(posedge clk) disable iff (rst)
      (commit[g] && !stage_we[g]) |=> act_q[g] == stage_q[g])
      else $error("commit did not copy staged value");

    assert_mask_hold_R9: assert property (@(posedge clk) disable iff (rst)
      (pwr_we && !pwr_mask[g]) |=> $stable(pwr_q[g])) else $error("unmasked channel changed mode");
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= 1'b1;
      ext_q <= 1'b0;
    end else if (ref_we) begin
      ref_q <= ref_val;
      ext_q <= ~ref_val;
    end
  end

  assert_ref_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !ref_we |=> $stable(ref_q)) else $error("reference changed without command");

  assert_ext_flag_R10: assert property (@(posedge clk) disable iff (rst)
    ext_q != ref_q) else $error("external flag inconsistent with reference");
endmodule

// File: rtl/octdac_cmd_top.sv
module octdac_cmd_top
  import octdac_pkg::*;
#(
  parameter int NCH         = 8,
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              sync_n,
  input  logic              sdin,
  output logic [NCH*DW-1:0] dac_code,
  output logic [2*NCH-1:0]  pd_mode,
  output logic              ref_on,
  output logic              ext_ref
);
  logic               word_vld;
  logic [FRAME_W-1:0] word;
  logic [NCH-1:0]     stage_we, commit, pwr_mask;
  logic [DW-1:0]      value;
  logic               pwr_we, ref_we, ref_val;
  logic [1:0]         pwr_sel;
  logic [NCH-1:0][DW-1:0] act_q;
  logic [NCH-1:0][1:0]    pwr_q;

  octdac_serial_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst(rst), .sclk(sclk), .sync_n(sync_n), .sdin(sdin),
    .word_vld(word_vld), .word(word)
  );

  octdac_decode #(.NCH(NCH), .DW(DW)) u_dec (
    .clk(clk), .rst(rst), .word_vld(word_vld), .word(word),
    .stage_we(stage_we), .commit(commit), .value(value),
    .pwr_we(pwr_we), .pwr_mask(pwr_mask), .pwr_sel(pwr_sel),
    .ref_we(ref_we), .ref_val(ref_val)
  );

  octdac_chan_regs #(.NCH(NCH), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .stage_we(stage_we), .commit(commit), .value(value),
    .pwr_we(pwr_we), .pwr_mask(pwr_mask), .pwr_sel(pwr_sel),
    .ref_we(ref_we), .ref_val(ref_val),
    .act_q(act_q), .pwr_q(pwr_q), .ref_q(ref_on), .ext_q(ext_ref)
  );

  assign dac_code = act_q;
  assign pd_mode  = pwr_q;
endmodule

// File: tb/octdac_cmd_top_bench.sv
`timescale 1ns/1ps
module octdac_cmd_top_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b1;
  logic sync_n = 1'b1;
  logic sdin = 1'b0;
  logic [127:0] dac_code;
  logic [15:0]  pd_mode;
  logic ref_on, ext_ref;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [15:0] m_stage [8];
  logic [15:0] m_act   [8];
  logic [1:0]  m_pwr   [8];
  logic        m_ref, m_ext;

  always #2.5 clk = ~clk;

  octdac_cmd_top u_octdac_cmd_top (
    .clk(clk), .rst(rst), .sclk(sclk), .sync_n(sync_n), .sdin(sdin),
    .dac_code(dac_code), .pd_mode(pd_mode), .ref_on(ref_on), .ext_ref(ext_ref)
  );

  function automatic logic [31:0] mk(input logic [3:0] op, input logic [3:0] ad,
                                     input logic [15:0] d, input logic [3:0] f);
    return {1'b0, 3'b000, op, ad, d, f};
  endfunction

  function automatic logic [31:0] mk_pwr(input logic [3:0] ad, input logic [1:0] md,
                                         input logic [7:0] mask);
    return {1'b0, 3'b000, 4'b0100, ad, 10'd0, md, mask};
  endfunction

  function automatic logic [31:0] mk_ref(input logic [2:0] code);
    return {1'b0, 3'b000, 4'b1001, 4'h0, code, 17'd0};
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < 8; i++) begin
      m_stage[i] = '0; m_act[i] = '0; m_pwr[i] = 2'b00;
    end
    m_ref = 1'b1; m_ext = 1'b0;
  endfunction

  function automatic void model_apply(input logic [31:0] w);
    logic [3:0] op, ad;
    logic [15:0] d;
    logic sel;
    if (w[31]) return;
    op = w[27:24]; ad = w[23:20]; d = w[19:4];
    for (int i = 0; i < 8; i++) begin
      sel = (ad == 4'hF) || (ad == 4'(i));
      case (op)
        4'b0000: if (sel) m_stage[i] = d;
        4'b0010: if (sel) m_stage[i] = d;
        4'b0011: if (sel) begin m_stage[i] = d; m_act[i] = d; end
        4'b0100: if (w[i]) m_pwr[i] = w[9:8];
        default: ;
      endcase
    end
    if (op == 4'b0010)
      for (int i = 0; i < 8; i++) m_act[i] = m_stage[i];
    if (op == 4'b1001) begin
      if (w[19:17] == 3'b101) begin m_ref = 1'b1; m_ext = 1'b0; end
      if (w[19:17] == 3'b110) begin m_ref = 1'b0; m_ext = 1'b1; end
    end
  endfunction

  task automatic check_state(input string tag);
    logic [127:0] ec;
    logic [15:0]  ep;
    for (int i = 0; i < 8; i++) begin
      ec[i*16 +: 16] = m_act[i];
      ep[i*2 +: 2]   = m_pwr[i];
    end
    n_tests += 4;
    if (dac_code !== ec) begin
      n_fail++; $display("FAIL %s dac_code actual %h expected %h", tag, dac_code, ec);
    end
    if (pd_mode !== ep) begin
      n_fail++; $display("FAIL %s pd_mode actual %h expected %h", tag, pd_mode, ep);
    end
    if (ref_on !== m_ref) begin
      n_fail++; $display("FAIL %s ref_on actual %b expected %b", tag, ref_on, m_ref);
    end
    if (ext_ref !== m_ext) begin
      n_fail++; $display("FAIL %s ext_ref actual %b expected %b", tag, ext_ref, m_ext);
    end
  endtask

  task automatic put_bit(input logic b);
    @(negedge clk); sdin = b;
    repeat (3) @(negedge clk); sclk = 1'b0;
    repeat (4) @(negedge clk); sclk = 1'b1;
  endtask

  task automatic open_frame();
    @(negedge clk); sync_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic close_frame();
    repeat (4) @(negedge clk); sync_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] w);
    open_frame();
    for (int i = 31; i >= 0; i--) put_bit(w[i]);
    close_frame();
    model_apply(w);
  endtask

  task automatic send_chk(input logic [31:0] w, input string tag);
    send(w);
    check_state(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'd1234));
    model_reset();
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check_state("R12 reset");

    // R6 staging only, then R7 broadcast commit (A, B, G staged, H commits all)
    send_chk(mk(4'b0000, 4'd0, 16'h1111, 4'h0), "R6 stage A");
    send_chk(mk(4'b0000, 4'd1, 16'h2222, 4'h0), "R6 stage B");
    send_chk(mk(4'b0000, 4'd6, 16'h7777, 4'h0), "R6 stage G");
    send_chk(mk(4'b0010, 4'd7, 16'h8888, 4'h0), "R7 stage H commit all");

    // R8 sequential single-channel commits C..F, with R2 mid-frame check on C
    w = mk(4'b0011, 4'd2, 16'h3C3C, 4'h0);
    open_frame();
    for (int i = 31; i >= 1; i--) put_bit(w[i]);
    repeat (8) @(negedge clk);
    check_state("R2 after 31 edges");
    put_bit(w[0]);
    repeat (8) @(negedge clk);
    model_apply(w);
    check_state("R2 after 32nd edge");
    close_frame();
    send_chk(mk(4'b0011, 4'd3, 16'h4D4D, 4'h0), "R8 commit D");
    send_chk(mk(4'b0011, 4'd4, 16'h5E5E, 4'h0), "R8 commit E");
    send_chk(mk(4'b0011, 4'd5, 16'h6F6F, 4'h0), "R8 commit F");

    // R9 mixed power-down modes, address field nonzero and ignored
    send_chk(mk_pwr(4'd5, 2'b01, 8'h03), "R9 A,B 1k");
    send_chk(mk_pwr(4'hF, 2'b01, 8'h80), "R9 H 1k");
    send_chk(mk_pwr(4'd0, 2'b10, 8'h0C), "R9 C,D 100k");
    send_chk(mk_pwr(4'd9, 2'b10, 8'h20), "R9 F 100k");

    // R13 powered-down channels still take writes
    send_chk(mk(4'b0011, 4'd0, 16'hABCD, 4'h0), "R13 commit to powered-down A");
    send_chk(mk(4'b0000, 4'd7, 16'h0F0F, 4'h0), "R13 stage powered-down H");
    send_chk(mk(4'b0010, 4'd9, 16'hDEAD, 4'h0), "R5 invalid address commits all, stages none");

    // R10 reference handling
    send_chk(mk_ref(3'b101), "R10 reference on");
    send_chk(mk_pwr(4'd0, 2'b11, 8'hFF), "R9 all high impedance");
    send_chk(mk_ref(3'b110), "R10 reference off");
    send_chk(mk_ref(3'b011), "R10 other code ignored");
    send_chk(mk_pwr(4'd0, 2'b00, 8'h11), "R9 power back up A,E");

    // R5 global write
    send_chk(mk(4'b0011, 4'hF, 16'h5A5A, 4'h0), "R5 broadcast commit");
    send_chk(mk(4'b0000, 4'hF, 16'h1234, 4'h0), "R5 broadcast stage");
    send_chk(mk(4'b0010, 4'd12, 16'h0000, 4'h0), "R5 unmapped address commit all");

    // R4 guard bit
    send_chk(32'h8311_2340, "R4 guard bit set");
    // R11 unknown command
    send_chk(mk(4'b0111, 4'hF, 16'hFFFF, 4'hF), "R11 unknown command");
    // R1 reserved bits ignored
    send_chk({1'b0, 3'b111, 4'b0011, 4'd1, 16'hBEEF, 4'hA}, "R1 reserved bits");

    // R3 truncated frame
    w = mk(4'b0011, 4'hF, 16'h9999, 4'h0);
    open_frame();
    for (int i = 31; i >= 12; i--) put_bit(w[i]);
    close_frame();
    check_state("R3 truncated frame");
    // R3 over-long frame: second word must be ignored
    w = mk(4'b0011, 4'd3, 16'h7171, 4'h0);
    open_frame();
    for (int i = 31; i >= 0; i--) put_bit(w[i]);
    model_apply(w);
    w = mk(4'b0011, 4'hF, 16'hEEEE, 4'h0);
    for (int i = 31; i >= 0; i--) put_bit(w[i]);
    close_frame();
    check_state("R3 edges after 32nd ignored");

    // random mix
    for (int k = 0; k < 120; k++) begin
      logic [3:0] op, ad;
      int r;
      r = $urandom_range(0, 9);
      case (r)
        0, 1: op = 4'b0000;
        2:    op = 4'b0010;
        3, 4: op = 4'b0011;
        5, 6: op = 4'b0100;
        7:    op = 4'b1001;
        default: op = 4'($urandom);
      endcase
      ad = ($urandom_range(0, 3) == 0) ? 4'hF : 4'($urandom_range(0, 8));
      w = {($urandom_range(0, 15) == 0), 3'($urandom), op, ad, 16'($urandom), 4'($urandom)};
      if (op == 4'b1001) w[19:17] = ($urandom_range(0, 1) == 0) ? 3'b101 : 3'b110;
      send_chk(w, "R1 random frame");
    end

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule